// File: doc/BRIEF.md
# Mailbox Message Fragmenting Transmitter

This block sends a byte message from a local buffer to a peer through a slot-based mailbox transmit window. Each slot is 32 bits wide. The message is cut into fragments and each fragment is written into the mailbox as follows: first a 32-bit header word, then the fragment body packed four bytes per slot, then a one-cycle interrupt pulse to the peer. The fragment size comes from the mailbox depth sampled when the attempt starts. One slot of that depth is always kept free for the header.

A client starts a send by pulsing `start` with four values: the buffer base address, the message length, an 8-bit host address and an 8-bit client address. The block polls the mailbox free-slot count and peer readiness at a fixed cycle interval. It bounds every wait with a cycle timeout. A failed attempt restarts the message from its first byte, and the number of attempts is limited. The block ends every request with a single `done` pulse that gives the result and a byte count.

Top module: `mbx_frag_tx`

## Requirements
- R1: Each header word carries the host address in bits 15:8, the client address in bits 7:0, the fragment byte length in bits 24:16 and zeros in bits 30:25.
- R2: At attempt start the fragment capacity is min(depth×4, 511)−4 bytes. Fragments take that size until the last one, which takes the remainder. A depth below 2 slots fails the attempt with no mailbox write.
- R3: Bit 31 of a header is 1 only on the fragment whose length equals the bytes still unsent, and is 0 on every other fragment.
- R4: No header is written before at least one free slot is seen. No body is written before ceil(length/4) free slots are seen. `mb_wr_en` never rises while `mb_free` is 0.
- R5: Body slots follow the header back to back. Byte n of each slot (bits 8n+7:8n) comes from buffer address base+offset+n. In a final partial slot the unused upper bytes are zero.
- R6: `irq_gen` pulses for one cycle after the last body slot of each fragment. If `peer_ready` is low in the next cycle the attempt fails, and the next attempt resends from byte 0.
- R7: At most MAX_TRIES attempts are made. Each attempt first waits for `peer_ready`, and that wait expires after READY_TIMEOUT cycles and fails the attempt.
- R8: A wait for free slots that lasts more than SPACE_TIMEOUT cycles fails the attempt.
- R9: `done` is a one-cycle pulse. On success `done_ok`=1 and `done_bytes` equals the message length. On failure `done_ok`=0 and `done_bytes` holds the body bytes written in the final attempt.
- R10: A zero length or a zero base address makes `done` pulse with `done_ok`=0 in the cycle after `start`, with no mailbox write.
- R11: While reset is asserted, `busy`, `done`, `mb_wr_en` and `irq_gen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| msg_base | input | ADDR_W | Buffer byte address of the message (0 = null) |
| msg_len | input | LEN_W | Message length in bytes |
| host_addr | input | 8 | Sender address placed in headers |
| client_addr | input | 8 | Receiver address placed in headers |
| busy | output | 1 | A request is in progress |
| buf_addr | output | ADDR_W | Byte address of the buffer word being read |
| buf_data | input | 32 | Four bytes from buf_addr upward, lowest address in bits 7:0 |
| mb_depth | input | 8 | Mailbox depth in slots |
| mb_free | input | 8 | Free slots in the mailbox |
| peer_ready | input | 1 | Peer reports ready |
| mb_wr_en | output | 1 | Write one slot into the mailbox |
| mb_wr_data | output | 32 | Slot value being written |
| irq_gen | output | 1 | Interrupt pulse to the peer after a fragment |
| done | output | 1 | Request finished pulse |
| done_ok | output | 1 | Result qualifier for done |
| done_bytes | output | LEN_W | Byte count for done |

## Verification
The main function is exercised with several message shapes. A short message that leaves a padded tail checks packing. A message that exactly fills one fragment checks the completion flag without a trailing fragment. A message one byte over capacity yields a one-byte last fragment. A small depth produces many equal fragments. A large depth clips the capacity at 507 bytes, which leaves the fragments unaligned to slots. Each case is compared word by word against a header and body stream computed in the bench, so a wrong length field, flag, byte order or padding shows up as a different word. Directed runs then cover the failure paths: a peer that never becomes ready, a mailbox that stops draining, a peer that drops readiness after one fragment, a depth too small to hold any payload, and null or empty requests.

// File: rtl/mbx_tx_pkg.sv
package mbx_tx_pkg;

   localparam int SLOT_BYTES = 4;
   localparam int FLEN_W     = 9;
   localparam int FLEN_CAP   = (1 << FLEN_W) - 1;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ARM,
      ST_WAIT_RDY,
      ST_WAIT_HDR,
      ST_WAIT_BODY,
      ST_BODY,
      ST_IRQ,
      ST_CHECK,
      ST_FAIL
   } tx_state_e;

endpackage

// File: rtl/mbx_wait_timer.sv
module mbx_wait_timer #(
   parameter int POLL_GAP = 16,
   parameter int TMR_W    = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             active,
   input  logic             cond,
   input  logic [TMR_W-1:0] limit,
   output logic             hit,
   output logic             expired
);
   localparam int GAP_W = $clog2(POLL_GAP + 1);

   logic [GAP_W-1:0] gap_q;
   logic [TMR_W-1:0] tot_q;

   assign hit     = active && !arm && (gap_q == '0) && cond;
   assign expired = active && !arm && !hit && (tot_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= '0;
         tot_q <= '0;
      end else if (arm) begin
         gap_q <= GAP_W'(POLL_GAP);
         tot_q <= '0;
      end else if (active) begin
         if (tot_q != '1) tot_q <= tot_q + 1'b1;
         if (gap_q != '0)  gap_q <= gap_q - 1'b1;
         else if (!cond)   gap_q <= GAP_W'(POLL_GAP);
      end
   end
endmodule

// File: rtl/mbx_frag_hdr.sv
module mbx_frag_hdr
   import mbx_tx_pkg::*;
#(
   parameter int LEN_W = 12
) (
   input  logic [7:0]        depth,
   input  logic [9:0]        cap_in,
   input  logic [LEN_W-1:0]  remain,
   input  logic [7:0]        host,
   input  logic [7:0]        client,
   output logic [9:0]        cap_now,
   output logic              cap_ok,
   output logic [FLEN_W-1:0] frag_len,
   output logic              last,
   output logic [31:0]       hdr,
   output logic [7:0]        need_slots
);
   logic [9:0]       win_bytes;
   logic [9:0]       lim_bytes;
   logic [LEN_W-1:0] cap_ext;

   assign win_bytes = {depth, 2'b00};
   assign lim_bytes = (win_bytes > 10'(FLEN_CAP)) ? 10'(FLEN_CAP) : win_bytes;
   assign cap_ok    = (depth >= 8'd2);
   assign cap_now   = lim_bytes - 10'(SLOT_BYTES);

   assign cap_ext   = LEN_W'(cap_in);
   assign frag_len  = (remain < cap_ext) ? remain[FLEN_W-1:0] : cap_in[FLEN_W-1:0];
   assign last      = (LEN_W'(frag_len) == remain);
   assign hdr       = {last, 6'd0, frag_len, host, client};

   logic [FLEN_W:0] round_up;
   assign round_up   = {1'b0, frag_len} + (FLEN_W+1)'(SLOT_BYTES - 1);
   assign need_slots = 8'(round_up >> 2);
endmodule

// File: rtl/mbx_slot_pack.sv
module mbx_slot_pack (
   input  logic [31:0] raw,
   input  logic [2:0]  nbytes,
   output logic [31:0] slot
);
   for (genvar k = 0; k < 4; k++) begin : g_lane
      assign slot[8*k +: 8] = (3'(k) < nbytes) ? raw[8*k +: 8] : 8'h00;
   end
endmodule

// File: rtl/mbx_frag_tx.sv
module mbx_frag_tx
   import mbx_tx_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int LEN_W         = 12,
   parameter int MAX_TRIES     = 5,
   parameter int READY_TIMEOUT = 1000000,
   parameter int SPACE_TIMEOUT = 500000,
   parameter int POLL_GAP      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] msg_base,
   input  logic [LEN_W-1:0]  msg_len,
   input  logic [7:0]        host_addr,
   input  logic [7:0]        client_addr,
   output logic              busy,
   output logic [ADDR_W-1:0] buf_addr,
   input  logic [31:0]       buf_data,
   input  logic [7:0]        mb_depth,
   input  logic [7:0]        mb_free,
   input  logic              peer_ready,
   output logic              mb_wr_en,
   output logic [31:0]       mb_wr_data,
   output logic              irq_gen,
   output logic              done,
   output logic              done_ok,
   output logic [LEN_W-1:0]  done_bytes
);
   localparam int TMO_MAX = (READY_TIMEOUT > SPACE_TIMEOUT) ? READY_TIMEOUT : SPACE_TIMEOUT;
   localparam int TMR_W   = $clog2(TMO_MAX + 2);
   localparam int TRY_W   = $clog2(MAX_TRIES + 1);

   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("MAX_TRIES must be at least 1");
   end
   if (POLL_GAP < 1) begin : g_bad_gap
      $error("POLL_GAP must be at least 1 to let the free count settle");
   end
   if (LEN_W < 10 || LEN_W > ADDR_W) begin : g_bad_len
      $error("LEN_W must lie between 10 and ADDR_W");
   end

   tx_state_e          st_q;
   logic [ADDR_W-1:0]  base_q;
   logic [LEN_W-1:0]   len_q, off_q, rem_q;
   logic [7:0]         host_q, client_q;
   logic [9:0]         cap_q;
   logic [FLEN_W-1:0]  fleft_q;
   logic [TRY_W-1:0]   try_q;
   logic               arm_q;

   logic [9:0]         cap_now;
   logic               cap_ok;
   logic [FLEN_W-1:0]  frag_len;
   logic               frag_last;
   logic [31:0]        hdr_word;
   logic [7:0]         need_slots;

   mbx_frag_hdr #(.LEN_W(LEN_W)) u_hdr (
      .depth      (mb_depth),
      .cap_in     (cap_q),
      .remain     (rem_q),
      .host       (host_q),
      .client     (client_q),
      .cap_now    (cap_now),
      .cap_ok     (cap_ok),
      .frag_len   (frag_len),
      .last       (frag_last),
      .hdr        (hdr_word),
      .need_slots (need_slots)
   );

   logic [2:0]  nb;
   logic [31:0] body_slot;
   assign nb       = (fleft_q > FLEN_W'(SLOT_BYTES)) ? 3'd4 : fleft_q[2:0];
   assign buf_addr = base_q + ADDR_W'(off_q);

   mbx_slot_pack u_pack (
      .raw    (buf_data),
      .nbytes (nb),
      .slot   (body_slot)
   );

   logic             tmr_active, tmr_cond, tmr_hit, tmr_exp;
   logic [TMR_W-1:0] tmr_limit;

   always_comb begin
      tmr_active = 1'b0;
      tmr_cond   = 1'b0;
      unique case (st_q)
         ST_WAIT_RDY:  begin tmr_active = 1'b1; tmr_cond = peer_ready;             end
         ST_WAIT_HDR:  begin tmr_active = 1'b1; tmr_cond = (mb_free != 8'd0);      end
         ST_WAIT_BODY: begin tmr_active = 1'b1; tmr_cond = (mb_free >= need_slots); end
         default: ;
      endcase
   end
   assign tmr_limit = (st_q == ST_WAIT_RDY) ? TMR_W'(READY_TIMEOUT) : TMR_W'(SPACE_TIMEOUT);

   mbx_wait_timer #(.POLL_GAP(POLL_GAP), .TMR_W(TMR_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm_q),
      .active  (tmr_active),
      .cond    (tmr_cond),
      .limit   (tmr_limit),
      .hit     (tmr_hit),
      .expired (tmr_exp)
   );

   assign busy = (st_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         base_q     <= '0;
         len_q      <= '0;
         off_q      <= '0;
         rem_q      <= '0;
         host_q     <= '0;
         client_q   <= '0;
         cap_q      <= '0;
         fleft_q    <= '0;
         try_q      <= '0;
         arm_q      <= 1'b0;
         mb_wr_en   <= 1'b0;
         mb_wr_data <= '0;
         irq_gen    <= 1'b0;
         done       <= 1'b0;
         done_ok    <= 1'b0;
         done_bytes <= '0;
      end else begin
         mb_wr_en <= 1'b0;
         irq_gen  <= 1'b0;
         done     <= 1'b0;
         arm_q    <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  base_q   <= msg_base;
                  len_q    <= msg_len;
                  host_q   <= host_addr;
                  client_q <= client_addr;
                  try_q    <= '0;
                  if (msg_len == '0 || msg_base == '0) begin
                     done       <= 1'b1;
                     done_ok    <= 1'b0;
                     done_bytes <= '0;
                  end else begin
                     st_q <= ST_ARM;
                  end
               end
            end
            ST_ARM: begin
               off_q <= '0;
               rem_q <= len_q;
               arm_q <= 1'b1;
               st_q  <= ST_WAIT_RDY;
            end
            ST_WAIT_RDY: begin
               if (tmr_hit) begin
                  if (cap_ok) begin
                     cap_q <= cap_now;
                     arm_q <= 1'b1;
                     st_q  <= ST_WAIT_HDR;
                  end else begin
                     st_q <= ST_FAIL;
                  end
               end else if (tmr_exp) begin
                  st_q <= ST_FAIL;
               end
            end
            ST_WAIT_HDR: begin
               if (tmr_hit) begin
                  mb_wr_en   <= 1'b1;
                  mb_wr_data <= hdr_word;
                  fleft_q    <= frag_len;
                  arm_q      <= 1'b1;
                  st_q       <= ST_WAIT_BODY;
               end else if (tmr_exp) begin
                  st_q <= ST_FAIL;
               end
            end
            ST_WAIT_BODY: begin
               if (tmr_hit)      st_q <= ST_BODY;
               else if (tmr_exp) st_q <= ST_FAIL;
            end
            ST_BODY: begin
               mb_wr_en   <= 1'b1;
               mb_wr_data <= body_slot;
               off_q      <= off_q + LEN_W'(nb);
               fleft_q    <= fleft_q - FLEN_W'(nb);
               if (fleft_q <= FLEN_W'(SLOT_BYTES)) st_q <= ST_IRQ;
            end
            ST_IRQ: begin
               irq_gen <= 1'b1;
               st_q    <= ST_CHECK;
            end
            ST_CHECK: begin
               if (!peer_ready) begin
                  st_q <= ST_FAIL;
               end else if (frag_last) begin
                  done       <= 1'b1;
                  done_ok    <= 1'b1;
                  done_bytes <= len_q;
                  st_q       <= ST_IDLE;
               end else begin
                  rem_q <= rem_q - LEN_W'(frag_len);
                  arm_q <= 1'b1;
                  st_q  <= ST_WAIT_HDR;
               end
            end
            ST_FAIL: begin
               if (try_q == TRY_W'(MAX_TRIES - 1)) begin
                  done       <= 1'b1;
                  done_ok    <= 1'b0;
                  done_bytes <= off_q;
                  st_q       <= ST_IDLE;
               end else begin
                  try_q <= try_q + 1'b1;
                  st_q  <= ST_ARM;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R9: completion is reported by a single-cycle pulse
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: attempt counter stays within its bound
   a_r7_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
      try_q < TRY_W'(MAX_TRIES));

   // R6: the peer interrupt only follows a body slot write
   a_r6_irq_after_body: assert property (@(posedge clk) disable iff (!rst_n)
      irq_gen |-> $past(mb_wr_en));

   // R4: never push into a mailbox that reports no free slot
   a_r4_no_full_write: assert property (@(posedge clk) disable iff (!rst_n)
      mb_wr_en |-> (mb_free != 8'd0));

   // R2: a written header never announces more than the latched capacity
   a_r2_hdr_len: assert property (@(posedge clk) disable iff (!rst_n)
      (mb_wr_en && st_q == ST_WAIT_BODY) |->
         (mb_wr_data[24:16] != 9'd0) && (10'(mb_wr_data[24:16]) <= cap_q));
endmodule

// File: tb/tb_mbx_frag_tx.sv
module tb_mbx_frag_tx;
   localparam int RDY_TO = 200;
   localparam int SPC_TO = 300;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] msg_base = '0;
   logic [11:0] msg_len = '0;
   logic [7:0]  host_addr = '0, client_addr = '0;
   logic        busy;
   logic [15:0] buf_addr;
   logic [31:0] buf_data;
   logic [7:0]  mb_depth = 8'd8;
   logic [7:0]  mb_free;
   logic        peer_ready = 1'b1;
   logic        mb_wr_en, irq_gen, done, done_ok;
   logic [31:0] mb_wr_data;
   logic [11:0] done_bytes;

   always #5 clk = ~clk;

   mbx_frag_tx #(
      .ADDR_W(16), .LEN_W(12), .MAX_TRIES(5),
      .READY_TIMEOUT(RDY_TO), .SPACE_TIMEOUT(SPC_TO), .POLL_GAP(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .msg_base(msg_base),
      .msg_len(msg_len), .host_addr(host_addr), .client_addr(client_addr),
      .busy(busy), .buf_addr(buf_addr), .buf_data(buf_data),
      .mb_depth(mb_depth), .mb_free(mb_free), .peer_ready(peer_ready),
      .mb_wr_en(mb_wr_en), .mb_wr_data(mb_wr_data), .irq_gen(irq_gen),
      .done(done), .done_ok(done_ok), .done_bytes(done_bytes)
   );

   function automatic logic [7:0] bval(input logic [15:0] a);
      return (a[7:0] * 8'd7 + 8'd3) ^ a[15:8];
   endfunction

   assign buf_data = {bval(buf_addr + 16'd3), bval(buf_addr + 16'd2),
                      bval(buf_addr + 16'd1), bval(buf_addr)};

   // mailbox model
   logic        clr = 1'b0;
   logic        drain_on = 1'b1;
   logic [7:0]  fill;
   int          log_n, irq_cnt;
   logic [31:0] log_w [256];
   assign mb_free = mb_depth - fill;

   always @(posedge clk) begin
      if (clr) begin
         log_n   <= 0;
         irq_cnt <= 0;
         fill    <= 8'd0;
      end else begin
         if (mb_wr_en) begin
            if (log_n < 256) log_w[log_n] <= mb_wr_data;
            log_n <= log_n + 1;
         end
         if (irq_gen) irq_cnt <= irq_cnt + 1;
         fill <= fill + (mb_wr_en ? 8'd1 : 8'd0) - ((drain_on && fill != 8'd0) ? 8'd1 : 8'd0);
      end
   end

   int n_chk = 0, n_bad = 0;
   int cyc_all = 0;

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc_all <= cyc_all + 1;
      if (cyc_all > 190000) begin
         $display("FAIL watchdog: run did not end (act %0d cycles, exp < 190000)", cyc_all);
         n_bad = n_bad + 1;
         summary();
         $finish;
      end
   end

   task automatic chk(input logic cond, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   logic [31:0] exp_w [256];
   int          exp_n, exp_irq;

   task automatic build_exp(input logic [15:0] base, input int len, input logic [7:0] h,
                            input logic [7:0] c, input int depth);
      int cap, rem, off, f;
      logic [31:0] w;
      exp_n = 0; exp_irq = 0;
      cap = ((depth * 4 < 511) ? depth * 4 : 511) - 4;
      rem = len; off = 0;
      while (rem > 0) begin
         f = (rem < cap) ? rem : cap;
         exp_w[exp_n] = {(f == rem), 6'd0, f[8:0], h, c};
         exp_n++;
         for (int b = 0; b < f; b += 4) begin
            w = '0;
            for (int k = 0; k < 4; k++)
               if (b + k < f) w[8*k +: 8] = bval(16'(base + off + b + k));
            exp_w[exp_n] = w;
            exp_n++;
         end
         off += f; rem -= f; exp_irq++;
      end
   endtask

   task automatic run_msg(input logic [15:0] base, input logic [11:0] len,
                          input logic [7:0] h, input logic [7:0] c, input logic drop_first,
                          output logic ok_o, output logic [11:0] bytes_o, output int cyc_o);
      int hold;
      logic drop_arm;
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      msg_base = base; msg_len = len; host_addr = h; client_addr = c;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc_o = 1; hold = 0; drop_arm = drop_first;
      while (!done && cyc_o < 20000) begin
         if (drop_arm && irq_gen) begin
            peer_ready = 1'b0; drop_arm = 1'b0; hold = 6;
         end else if (hold > 0) begin
            hold--;
            if (hold == 0) peer_ready = 1'b1;
         end
         @(negedge clk);
         cyc_o++;
      end
      chk(done, "R9 done reached", cyc_o, 20000);
      ok_o = done_ok;
      bytes_o = done_bytes;
      @(negedge clk);
   endtask

   typedef logic [35:0] vec_t;  // {len, host, client, depth}
   localparam vec_t VECS [6] = '{
      {12'd5,   8'h21, 8'h07, 8'd8},
      {12'd28,  8'h10, 8'hA5, 8'd8},
      {12'd29,  8'h3C, 8'h01, 8'd8},
      {12'd60,  8'hFF, 8'h80, 8'd4},
      {12'd600, 8'h01, 8'hFE, 8'd200},
      {12'd3,   8'h55, 8'hAA, 8'd2}
   };

   initial begin
      logic ok;
      logic [11:0] nbytes;
      int cyc, bad_at;

      // R11: reset state
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mb_wr_en && !irq_gen, "R11 reset outputs quiet",
          {busy, done, mb_wr_en, irq_gen}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: R1 R2 R3 R4 R5 R6 R9
      for (int i = 0; i < 6; i++) begin
         logic [15:0] base;
         base = 16'h0100 + 16'(i) * 16'h0400;
         mb_depth = VECS[i][7:0];
         build_exp(base, int'(VECS[i][35:24]), VECS[i][23:16], VECS[i][15:8], int'(VECS[i][7:0]));
         run_msg(base, VECS[i][35:24], VECS[i][23:16], VECS[i][15:8], 1'b0, ok, nbytes, cyc);
         chk(log_n == exp_n, "R2 slot count", log_n, exp_n);
         bad_at = -1;
         for (int j = 0; j < exp_n && j < log_n; j++)
            if (bad_at < 0 && log_w[j] !== exp_w[j]) bad_at = j;
         if (bad_at >= 0)
            chk(1'b0, "R1/R3/R5 slot word", log_w[bad_at], exp_w[bad_at]);
         else
            chk(1'b1, "R1 R3 R5 slot words", 0, 0);
         chk(irq_cnt == exp_irq, "R6 irq per fragment", irq_cnt, exp_irq);
         chk(ok == 1'b1, "R9 ok on success", ok, 1);
         chk(nbytes == VECS[i][35:24], "R9 byte count", nbytes, VECS[i][35:24]);
      end

      // R10: zero length and null base
      mb_depth = 8'd8;
      run_msg(16'h0200, 12'd0, 8'h01, 8'h02, 1'b0, ok, nbytes, cyc);
      chk(cyc == 1 && !ok, "R10 zero length fails at once", cyc, 1);
      chk(log_n == 0, "R10 zero length no write", log_n, 0);
      run_msg(16'h0000, 12'd8, 8'h01, 8'h02, 1'b0, ok, nbytes, cyc);
      chk(cyc == 1 && !ok, "R10 null base fails at once", cyc, 1);
      chk(log_n == 0, "R10 null base no write", log_n, 0);

      // R7: peer never ready, five timed-out attempts
      peer_ready = 1'b0;
      run_msg(16'h0300, 12'd8, 8'h01, 8'h02, 1'b0, ok, nbytes, cyc);
      chk(!ok && log_n == 0, "R7 not ready fails without write", log_n, 0);
      chk(cyc >= 5 * RDY_TO && cyc < 5 * RDY_TO + 100, "R7 five ready timeouts", cyc, 5 * RDY_TO);
      chk(nbytes == 12'd0, "R9 failure byte count", nbytes, 0);
      peer_ready = 1'b1;
      @(negedge clk);

      // R2: depth too small for any payload
      mb_depth = 8'd1;
      run_msg(16'h0300, 12'd8, 8'h01, 8'h02, 1'b0, ok, nbytes, cyc);
      chk(!ok && log_n == 0, "R2 depth 1 fails without write", log_n, 0);

      // R8 R4: mailbox stops draining, later headers time out
      mb_depth = 8'd4;
      drain_on = 1'b0;
      run_msg(16'h0500, 12'd30, 8'h11, 8'h22, 1'b0, ok, nbytes, cyc);
      chk(!ok, "R8 space timeout fails", ok, 0);
      chk(log_n == 4, "R4 R8 only first fragment fits", log_n, 4);
      chk(log_w[0] == {1'b0, 6'd0, 9'd12, 8'h11, 8'h22}, "R3 non-final header", log_w[0],
          {1'b0, 6'd0, 9'd12, 8'h11, 8'h22});
      chk(irq_cnt == 1, "R6 single irq before stall", irq_cnt, 1);
      chk(cyc >= 5 * SPC_TO, "R8 waits bounded by timeout", cyc, 5 * SPC_TO);
      drain_on = 1'b1;

      // R6: peer drops ready after first fragment, retry restarts from byte 0
      mb_depth = 8'd8;
      build_exp(16'h0700, 29, 8'h44, 8'h55, 8);
      run_msg(16'h0700, 12'd29, 8'h44, 8'h55, 1'b1, ok, nbytes, cyc);
      chk(ok && nbytes == 12'd29, "R6 retry succeeds", nbytes, 29);
      chk(log_n == 8 + exp_n, "R6 first fragment resent", log_n, 8 + exp_n);
      chk(irq_cnt == 3, "R6 irq count with retry", irq_cnt, 3);
      chk(log_n > 8 && log_w[8] == exp_w[0], "R6 restart header", log_w[8], exp_w[0]);

      summary();
      $finish;
   end
endmodule